// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide, two-address programming front end of an eight-line interrupt controller. Software reaches it through one address bit, a write strobe with a data byte, and a read strobe. On address 0 a write is either an initialization word, a read/poll control word or one of eight end-of-service and rotation commands, depending on bits 4 and 3. On address 1 a write either feeds the initialization sequence or, once the controller is configured, loads the interrupt mask. Reads on address 0 return a poll result, the in-service vector or the request vector. Reads on address 1 return the mask.

The request and in-service vectors belong to the surrounding controller and come in as inputs. The block drives back one-hot in-service clear strobes, an init pulse that tells the controller to flush its own state, and the configuration it holds: mask, vector base, rotation base and the mode flags. Two instances of a rotating priority picker find the highest-priority in-service line for non-specific end-of-service commands and the best unmasked request for polling.

The initialization sequencer is a four-state machine. READY is the normal operating state. An initialization word on address 0 takes it to WAIT_BASE from any state. In WAIT_BASE, an address-1 write loads the vector base and moves to WAIT_CASC. In WAIT_CASC, an address-1 write moves to WAIT_MODE if the initialization word asked for a mode word, and back to READY if it did not. In WAIT_MODE, an address-1 write loads the mode flags and returns to READY.

Top module: `icu_cmd_port`

## Requirements
- R1: Reset leaves every held register at zero and the sequencer in READY (`cfg_ready` high). An address-0 write with bit 4 set does three things: it pulses `init_clr` in that cycle, it clears the mask, vector base, rotation base and all mode flags, and it moves to WAIT_BASE. Its bit 0 is recorded as "mode word expected".
- R2: In WAIT_BASE, an address-1 write stores data bits 7:3 in `vec_base` and moves to WAIT_CASC.
- R3: In WAIT_CASC, an address-1 write changes no register. It moves to WAIT_MODE when a mode word is expected, otherwise to READY.
- R4: In WAIT_MODE, an address-1 write sets `nested` from bit 4 and `auto_eoi` from bit 1, then returns to READY.
- R5: In READY, an address-1 write loads `mask_q`. Outside READY, such a write leaves the mask unchanged. Address-1 read data is always the mask.
- R6: An address-0 write with bit 4 clear and bit 3 set is a read/poll control word. Bit 2 set makes a poll pending. With bit 1 set, bit 0 sets `read_svc` (1 selects in-service, 0 selects request). With bit 6 set, bit 5 sets `special_mask`.
- R7: An address-0 write with bits 4 and 3 clear is a command coded in bits 7:5. Codes 0 and 4 set `rot_on_aeoi` from bit 7. Code 2 changes nothing.
- R8: Codes 1 and 5 pulse `svc_clr`, in the write cycle, on the highest-priority in-service line. Priority counts upward from `rot_base`, modulo 8. Code 5 also sets `rot_base` to that line plus 1, modulo 8. With no in-service line, neither code has any effect.
- R9: Code 3 pulses `svc_clr` on the line in bits 2:0. Code 7 does the same and also sets `rot_base` to that line plus 1, modulo 8.
- R10: Code 6 sets `rot_base` to bits 2:0 plus 1, modulo 8, and clears nothing.
- R11: Address-0 read data is the poll byte while a poll is pending. Otherwise it is `svc_vec` when `read_svc` is set and `req_vec` when it is clear. An address-0 read with a poll pending clears the poll.
- R12: The poll byte holds the number of the highest-priority unmasked request line, provided that line ranks strictly above the highest in-service line or nothing is in service. Otherwise the poll byte is 8'h07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| req_vec | input | 8 | Request vector from the controller |
| svc_vec | input | 8 | In-service vector from the controller |
| rd_data | output | 8 | Read data, combinational |
| mask_q | output | 8 | Interrupt mask |
| vec_base | output | 5 | Vector base, upper five bits of the vector number |
| rot_base | output | 3 | Line with highest priority |
| svc_clr | output | 8 | One-hot in-service clear strobe |
| init_clr | output | 1 | Pulse telling the controller to flush its state |
| auto_eoi | output | 1 | Automatic end-of-service mode |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-service |
| nested | output | 1 | Fully nested mode |
| special_mask | output | 1 | Special mask mode |
| poll_pend | output | 1 | Poll read pending |
| read_svc | output | 1 | Address-0 read selects in-service vector |
| cfg_ready | output | 1 | Sequencer is in READY |

## Verification
The bench builds the block with its default of eight lines. That is the only width for which the three-bit line fields fill the whole rotation range, so every rotation base can be reached. It also makes the wrap from line 7 to line 0 on rotating commands, and the wrap of the priority scan past line 7, reachable. Random traffic, drawn from a fixed seed and with random request and in-service vectors, puts the sequencer in every state. That traffic interleaves initialization words with commands, so commands arriving in the middle of initialization and polls competing with in-service lines are covered too.

// File: rtl/icu_cmd_pkg.sv
package icu_cmd_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_WAIT_BASE = 2'd1,
        ST_WAIT_CASC = 2'd2,
        ST_WAIT_MODE = 2'd3
    } init_st_e;

    typedef enum logic [2:0] {
        CMD_ROT_CLR      = 3'd0,
        CMD_EOI          = 3'd1,
        CMD_NOP          = 3'd2,
        CMD_EOI_SPEC     = 3'd3,
        CMD_ROT_SET      = 3'd4,
        CMD_EOI_ROT      = 3'd5,
        CMD_SET_PRIO     = 3'd6,
        CMD_EOI_SPEC_ROT = 3'd7
    } cmd_e;
endpackage

// File: rtl/icu_prio_pick.sv
module icu_prio_pick #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [LW-1:0]    base,
    output logic             found,
    output logic [LW-1:0]    line,
    output logic [LW-1:0]    rank
);
    logic [LW-1:0] idx;

    // scan from base upward, wrapping, first set bit wins
    always_comb begin
        found = 1'b0;
        line  = '0;
        rank  = '0;
        idx   = '0;
        for (int i = 0; i < LINES; i++) begin
            idx = base + LW'(i);
            if (!found && vec[idx]) begin
                found = 1'b1;
                line  = idx;
                rank  = LW'(i);
            end
        end
    end
endmodule

// File: rtl/icu_init_seq.sv
module icu_init_seq
    import icu_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     need_mode,
    input  logic     wr_hi,
    output init_st_e state,
    output logic     ld_base,
    output logic     ld_mode
);
    init_st_e nxt;
    logic     mode_exp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READY;
            mode_exp <= 1'b0;
        end else begin
            state <= nxt;
            if (start) mode_exp <= need_mode;
        end
    end

    always_comb begin
        nxt     = state;
        ld_base = 1'b0;
        ld_mode = 1'b0;
        if (start) begin
            nxt = ST_WAIT_BASE;
        end else if (wr_hi) begin
            unique case (state)
                ST_READY:     nxt = ST_READY;
                ST_WAIT_BASE: begin
                    ld_base = 1'b1;
                    nxt     = ST_WAIT_CASC;
                end
                ST_WAIT_CASC: nxt = mode_exp ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE: begin
                    ld_mode = 1'b1;
                    nxt     = ST_READY;
                end
            endcase
        end
    end

    assert_base_to_casc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_base |=> state == ST_WAIT_CASC);
    assert_mode_to_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mode |=> state == ST_READY);
    assert_start_to_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> state == ST_WAIT_BASE);
endmodule

// File: rtl/icu_cmd_port.sv
module icu_cmd_port
    import icu_cmd_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES),
    localparam int BW = DW - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [LINES-1:0] req_vec,
    input  logic [LINES-1:0] svc_vec,
    output logic [DW-1:0]    rd_data,
    output logic [LINES-1:0] mask_q,
    output logic [BW-1:0]    vec_base,
    output logic [LW-1:0]    rot_base,
    output logic [LINES-1:0] svc_clr,
    output logic             init_clr,
    output logic             auto_eoi,
    output logic             rot_on_aeoi,
    output logic             nested,
    output logic             special_mask,
    output logic             poll_pend,
    output logic             read_svc,
    output logic             cfg_ready
);
    logic     wr_lo, wr_hi, is_init, is_ctl, is_cmd, poll_take;
    cmd_e     cmd;
    logic [LW-1:0] sel_line;
    init_st_e st;
    logic     ld_base, ld_mode;

    logic          s_found, r_found;
    logic [LW-1:0] s_line, s_rank, r_line, r_rank;
    logic          poll_hit;
    logic [DW-1:0] poll_byte;

    logic          rb_ld, rae_ld;
    logic [LW-1:0] rb_val;

    assign wr_lo    = wr_en & ~addr;
    assign wr_hi    = wr_en & addr;
    assign is_init  = wr_lo & wr_data[4];
    assign is_ctl   = wr_lo & ~wr_data[4] & wr_data[3];
    assign is_cmd   = wr_lo & ~wr_data[4] & ~wr_data[3];
    assign cmd      = cmd_e'(wr_data[7:5]);
    assign sel_line = wr_data[LW-1:0];
    assign init_clr = is_init;
    assign cfg_ready = (st == ST_READY);

    icu_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (is_init),
        .need_mode (wr_data[0]),
        .wr_hi     (wr_hi),
        .state     (st),
        .ld_base   (ld_base),
        .ld_mode   (ld_mode)
    );

    icu_prio_pick #(.LINES(LINES)) u_svc_pick (
        .vec   (svc_vec),
        .base  (rot_base),
        .found (s_found),
        .line  (s_line),
        .rank  (s_rank)
    );

    icu_prio_pick #(.LINES(LINES)) u_req_pick (
        .vec   (req_vec & ~mask_q),
        .base  (rot_base),
        .found (r_found),
        .line  (r_line),
        .rank  (r_rank)
    );

    // command decode: clear strobes and rotation updates
    always_comb begin
        svc_clr = '0;
        rb_ld   = 1'b0;
        rb_val  = rot_base;
        rae_ld  = 1'b0;
        if (is_cmd) begin
            unique case (cmd)
                CMD_ROT_CLR, CMD_ROT_SET: rae_ld = 1'b1;
                CMD_EOI, CMD_EOI_ROT: begin
                    if (s_found) begin
                        svc_clr = LINES'(1) << s_line;
                        if (cmd == CMD_EOI_ROT) begin
                            rb_ld  = 1'b1;
                            rb_val = s_line + LW'(1);
                        end
                    end
                end
                CMD_EOI_SPEC: svc_clr = LINES'(1) << sel_line;
                CMD_EOI_SPEC_ROT: begin
                    svc_clr = LINES'(1) << sel_line;
                    rb_ld   = 1'b1;
                    rb_val  = sel_line + LW'(1);
                end
                CMD_SET_PRIO: begin
                    rb_ld  = 1'b1;
                    rb_val = sel_line + LW'(1);
                end
                CMD_NOP: ;
            endcase
        end
    end

    assign poll_hit  = r_found && (!s_found || (r_rank < s_rank));
    assign poll_byte = poll_hit ? {{BW{1'b0}}, r_line} : DW'(7);
    assign poll_take = rd_en & ~addr & poll_pend;

    always_comb begin
        if (addr)           rd_data = mask_q;
        else if (poll_pend) rd_data = poll_byte;
        else if (read_svc)  rd_data = svc_vec;
        else                rd_data = req_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || is_init) begin
            mask_q       <= '0;
            vec_base     <= '0;
            rot_base     <= '0;
            rot_on_aeoi  <= 1'b0;
            auto_eoi     <= 1'b0;
            nested       <= 1'b0;
            special_mask <= 1'b0;
            poll_pend    <= 1'b0;
            read_svc     <= 1'b0;
        end else begin
            if (poll_take) poll_pend <= 1'b0;
            if (is_ctl) begin
                if (wr_data[2]) poll_pend    <= 1'b1;
                if (wr_data[1]) read_svc     <= wr_data[0];
                if (wr_data[6]) special_mask <= wr_data[5];
            end
            if (rae_ld) rot_on_aeoi <= wr_data[7];
            if (rb_ld)  rot_base    <= rb_val;
            if (ld_base) vec_base   <= wr_data[DW-1:LW];
            if (ld_mode) begin
                nested   <= wr_data[4];
                auto_eoi <= wr_data[1];
            end
            if (wr_hi && st == ST_READY) mask_q <= wr_data;
        end
    end

    assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_init |=> (mask_q == '0 && rot_base == '0 && !cfg_ready && !poll_pend));
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
    assert_clr_from_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_clr != '0) |-> (wr_en && !addr && !wr_data[4] && !wr_data[3]));
    assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_clr));
    assert_poll_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_take && !wr_en) |=> !poll_pend);
    assert_prio_only_rotation_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(rot_base));
endmodule

// File: tb/sim_icu_cmd_port.sv
module sim_icu_cmd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, req_vec = '0, svc_vec = '0;
    logic [7:0] rd_data, mask_q, svc_clr;
    logic [4:0] vec_base;
    logic [2:0] rot_base;
    logic       init_clr, auto_eoi, rot_on_aeoi, nested, special_mask;
    logic       poll_pend, read_svc, cfg_ready;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_mask;
    logic [4:0] m_vb;
    logic [2:0] m_rb;
    logic       m_rae, m_aeoi, m_nest, m_smask, m_poll, m_rsel, m_need;
    int         m_st;

    always #5 clk = ~clk;

    icu_cmd_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .req_vec(req_vec), .svc_vec(svc_vec), .rd_data(rd_data),
        .mask_q(mask_q), .vec_base(vec_base), .rot_base(rot_base), .svc_clr(svc_clr),
        .init_clr(init_clr), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
        .nested(nested), .special_mask(special_mask), .poll_pend(poll_pend),
        .read_svc(read_svc), .cfg_ready(cfg_ready)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // {found, line} of first set bit scanning up from base, wrapping
    function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] b);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] k;
            k = b + 3'(i);
            if (v[k]) return {1'b1, k};
        end
        return 4'h0;
    endfunction

    function automatic logic [7:0] poll_exp(input logic [7:0] rq, input logic [7:0] sv);
        logic [3:0] r, s;
        logic [2:0] rr, sr;
        r  = pick(rq & ~m_mask, m_rb);
        s  = pick(sv, m_rb);
        rr = r[2:0] - m_rb;
        sr = s[2:0] - m_rb;
        if (r[3] && (!s[3] || rr < sr)) return {5'd0, r[2:0]};
        return 8'h07;
    endfunction

    task automatic model_reset();
        m_mask = '0; m_vb = '0; m_rb = '0; m_rae = 0; m_aeoi = 0;
        m_nest = 0; m_smask = 0; m_poll = 0; m_rsel = 0;
    endtask

    task automatic check_regs();
        chk("R5 mask", mask_q, m_mask);
        chk("R2 vec_base", {3'd0, vec_base}, {3'd0, m_vb});
        chk("R10 rot_base", {5'd0, rot_base}, {5'd0, m_rb});
        chk("R7 rot_on_aeoi", {7'd0, rot_on_aeoi}, {7'd0, m_rae});
        chk("R4 auto_eoi/nested", {6'd0, auto_eoi, nested}, {6'd0, m_aeoi, m_nest});
        chk("R6 flags", {5'd0, special_mask, poll_pend, read_svc}, {5'd0, m_smask, m_poll, m_rsel});
        chk("R3 cfg_ready", {7'd0, cfg_ready}, {7'd0, (m_st == 0)});
    endtask

    task automatic apply(input logic a, input logic we, input logic [7:0] d,
                         input logic re, input logic [7:0] rq, input logic [7:0] sv);
        logic [7:0] e_clr, e_rd;
        logic [3:0] s;
        addr = a; wr_en = we; wr_data = d; rd_en = re; req_vec = rq; svc_vec = sv;
        #2;
        e_clr = '0;
        s = pick(sv, m_rb);
        if (we && !a && !d[4] && !d[3]) begin
            case (d[7:5])
                3'd1, 3'd5: if (s[3]) e_clr = 8'd1 << s[2:0];
                3'd3, 3'd7: e_clr = 8'd1 << d[2:0];
                default: ;
            endcase
        end
        chk("R8 R9 svc_clr", svc_clr, e_clr);
        chk("R1 init_clr", {7'd0, init_clr}, {7'd0, (we && !a && d[4])});
        if (re) begin
            e_rd = a ? m_mask : (m_poll ? poll_exp(rq, sv) : (m_rsel ? sv : rq));
            chk(m_poll && !a ? "R12 poll byte" : "R11 R5 read data", rd_data, e_rd);
        end
        @(posedge clk);
        if (we && !a && d[4]) begin
            model_reset();
            m_st = 1;
            m_need = d[0];
        end else begin
            if (re && !a && m_poll) m_poll = 0;
            if (we && !a && d[3]) begin
                if (d[2]) m_poll = 1;
                if (d[1]) m_rsel = d[0];
                if (d[6]) m_smask = d[5];
            end else if (we && !a) begin
                case (d[7:5])
                    3'd0, 3'd4: m_rae = d[7];
                    3'd5: if (s[3]) m_rb = s[2:0] + 3'd1;
                    3'd6, 3'd7: m_rb = d[2:0] + 3'd1;
                    default: ;
                endcase
            end
            if (we && a) begin
                case (m_st)
                    0: m_mask = d;
                    1: begin m_vb = d[7:3]; m_st = 2; end
                    2: m_st = m_need ? 3 : 0;
                    default: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
                endcase
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check_regs();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        m_st = 0; m_need = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_regs();                                   // R1 reset state

        // R1..R4: full sequence with mode word
        apply(0, 1, 8'h11, 0, 8'h00, 8'h00);
        apply(1, 1, 8'h4F, 0, 8'h00, 8'h00);            // R2 base 9
        apply(1, 1, 8'hFF, 0, 8'h00, 8'h00);            // R3 mask untouched
        apply(1, 1, 8'h12, 0, 8'h00, 8'h00);            // R4 nested + auto
        apply(1, 1, 8'h00, 1, 8'h00, 8'h00);            // R5 mask 0
        // R8: rotating non-specific, then plain non-specific wraps past 7
        apply(0, 1, 8'hA0, 0, 8'h00, 8'h81);            // clear 0, base 1
        apply(0, 1, 8'h20, 0, 8'h00, 8'h81);            // clear 7
        apply(0, 1, 8'h20, 0, 8'h00, 8'h00);            // R8 empty: no effect
        apply(0, 1, 8'hE7, 0, 8'h00, 8'h00);            // R9 line 7, base 0
        apply(0, 1, 8'hC3, 0, 8'h00, 8'h00);            // R10 base 4
        apply(0, 1, 8'h40, 0, 8'hFF, 8'hFF);            // R7 code 2 nothing
        apply(0, 1, 8'h80, 0, 8'h00, 8'h00);            // R7 rot_on_aeoi 1
        // R6/R11/R12 poll
        apply(0, 1, 8'h0C, 0, 8'h00, 8'h00);
        apply(0, 0, 8'h00, 1, 8'h10, 8'h00);            // poll returns 4
        apply(0, 1, 8'h0C, 0, 8'h00, 8'h00);
        apply(0, 0, 8'h00, 1, 8'h00, 8'h00);            // poll none -> 7
        apply(0, 1, 8'h0B, 0, 8'h00, 8'h00);            // R6 select in-service
        apply(0, 0, 8'h00, 1, 8'h3C, 8'h5A);            // R11 reads svc
        apply(0, 1, 8'h68, 0, 8'h00, 8'h00);            // R6 special mask on
        // R3: short sequence without mode word
        apply(0, 1, 8'h10, 0, 8'h00, 8'h00);
        apply(1, 1, 8'hF8, 0, 8'h00, 8'h00);
        apply(1, 1, 8'h00, 0, 8'h00, 8'h00);            // back to READY
        apply(1, 1, 8'hA5, 1, 8'h00, 8'h00);

        for (int n = 0; n < 3000; n++) begin
            int kind;
            logic [7:0] d;
            kind = $urandom_range(0, 12);
            d = 8'($urandom);
            case (kind)
                0:          apply(0, 1, d | 8'h10, 0, 8'($urandom), 8'($urandom));
                1, 2, 3:    apply(1, 1, d, $urandom_range(0, 1) == 1, 8'($urandom), 8'($urandom));
                4, 5:       apply(0, 1, (d & 8'hE7) | 8'h08, 0, 8'($urandom), 8'($urandom));
                6, 7, 8:    apply(0, 1, d & 8'hE7, 0, 8'($urandom), 8'($urandom));
                9, 10:      apply(0, 0, d, 1, 8'($urandom), 8'($urandom));
                11:         apply(1, 0, d, 1, 8'($urandom), 8'($urandom));
                default:    apply(0, 0, d, 0, 8'($urandom), 8'($urandom));
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule